// File: doc/BRIEF.md
# Standby Wakeup Sequencer

This block controls a low-power standby state for a small controller. A sleep request from the core moves the block into one of two low-power states. With the standby-enable bit clear, it enters an ordinary sleep. With the bit set, it enters software standby. In both states the system clock enable is held low.

An interrupt edge of the selected polarity ends either state. Leaving ordinary sleep is immediate. Leaving software standby first runs a stabilization countdown, whose length is chosen by a 3-bit wait code. Only when that countdown ends are the clocks restored.

Two further pins override everything above. Holding the reset pin low keeps the clocks running and holds the block in a reset state. Releasing the reset pin gives a one-cycle pulse that starts reset handling. Pulling the hardware-standby pin low forces a hardware standby state from any mode.

All three pins pass through two-flop synchronizers. The block also outputs the programmed wait length, so that it can be compared against the oscillator settling budget.

Top module: `stby_wake_seq`

## Requirements
- R1: With the block running, a `sleep_req` high at a clock edge moves it to software standby (`in_swstby`=1) when `stby_en`=1, or to ordinary sleep (`in_sleep`=1) when `stby_en`=0. In both cases `clk_en` is 0 from that edge on.
- R2: `wait_count` follows `wait_sel` as shown below. Each code from 000 to 101 gives more than 4096 states.

  | `wait_sel` | `wait_count` (states) |
  |---|---|
  | 000 | 8192 |
  | 001 | 16384 |
  | 010 | 32768 |
  | 011 | 65536 |
  | 100 | 131072 |
  | 101 | 262144 |
  | 110 | 262144 |
  | 111 | 16 |

- R3: `cfg_err` is 1 when `wait_sel`=110. It is also 1 for 111 when the parameter FLASH_VARIANT=1. Otherwise it is 0.
- R4: The wake edge is a falling edge on `irq_pin` when `edge_rise`=0 and a rising edge when `edge_rise`=1. An edge of the opposite polarity leaves the block in its low-power state.
- R5: Suppose a wake edge reaches `irq_pin` during software standby, with N the count for the current code. `clk_en` then rises at the (N+4)th rising clock edge after the pin change. `wake_pulse` is high for exactly that one cycle.
- R6: Interrupt edges have no effect while the block is running, and they do not restart a countdown that is already in progress.
- R7: A wake edge during ordinary sleep raises `clk_en` and `wake_pulse` at the 3rd rising clock edge after the pin change, with no countdown.
- R8: Suppose `rst_pin_n` goes low while `hwstby_pin_n` is high. At the 3rd clock edge the block leaves any low-power state and holds `clk_en`=1. When `rst_pin_n` returns high, `rst_exc` pulses for one cycle at the 3rd edge after that change.
- R9: Suppose `hwstby_pin_n` goes low in any mode, including during a countdown. At the 3rd clock edge, `in_hwstby`=1 and `clk_en`=0, and no `wake_pulse` follows. When the pin is released, the block passes through the reset state at the 3rd edge, and `rst_exc` pulses at the 4th edge.
- R10: After `rst`, the block is running with `clk_en`=1, and every status flag and pulse is 0.

Port descriptions are below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_pin_n | input | 1 | External reset pin, active low |
| hwstby_pin_n | input | 1 | Hardware standby pin, active low |
| irq_pin | input | 1 | External interrupt pin |
| sleep_req | input | 1 | Sleep request from the core |
| stby_en | input | 1 | Selects software standby over ordinary sleep |
| edge_rise | input | 1 | Wake edge polarity: 1 rising, 0 falling |
| wait_sel | input | 3 | Stabilization wait code |
| clk_en | output | 1 | System clock enable |
| in_sleep | output | 1 | Ordinary sleep active |
| in_swstby | output | 1 | Software standby active |
| in_hwstby | output | 1 | Hardware standby active |
| wake_pulse | output | 1 | One-cycle pulse when clocks return after a wake |
| rst_exc | output | 1 | One-cycle pulse when the reset pin is released |
| cfg_err | output | 1 | Illegal wait code selected |
| wait_count | output | 19 | Programmed wait length in clock states |

## Verification
Every pin change lands in the state register at the third rising edge: two edges for the synchronizer, then one for the edge detector or level decode. Each check is therefore placed that many edges after the pin is driven. A countdown wake is timed by counting rising edges from the pin change until `clk_en` is seen high, and the bench requires exactly N+4 edges for each code it tries. `sleep_req` and the wait code are not synchronized, so their results are due one edge after they are driven. All outputs are sampled on the falling clock edge.

// File: rtl/stbw_pkg.sv
package stbw_pkg;

    localparam int CNT_W = 19;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_SLEEP  = 3'd1,
        ST_SWSTBY = 3'd2,
        ST_STAB   = 3'd3,
        ST_RESET  = 3'd4,
        ST_HWSTBY = 3'd5
    } stbw_state_e;

    // Stabilization length in clock states for a wait code.
    function automatic logic [CNT_W-1:0] wait_states(input logic [2:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            3'b110:  n = CNT_W'(262144);
            3'b111:  n = CNT_W'(16);
            default: n = CNT_W'(8192) << code;
        endcase
        return n;
    endfunction

    function automatic logic code_illegal(input logic [2:0] code, input logic flash);
        return (code == 3'b110) || (flash && (code == 3'b111));
    endfunction

endpackage

// File: rtl/stbw_sync.sv
module stbw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= RST_VAL;
                else if (i == 0)
                    chain[i] <= d;
                else
                    chain[i] <= chain[(i > 0) ? i-1 : 0];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/stbw_edge.sv
module stbw_edge (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    input  logic rise_sel,
    output logic hit
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sig;
    end

    assign hit = rise_sel ? (sig & ~prev) : (~sig & prev);

    // R4: a detected edge always matches the selected polarity
    a_r4_polarity: assert property (@(posedge clk) disable iff (rst)
        hit |-> (sig == rise_sel));
endmodule

// File: rtl/stbw_timer.sv
module stbw_timer #(
    parameter int W = stbw_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R6: without a load the count never climbs back up
    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        !load |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/stby_wake_seq.sv
module stby_wake_seq #(
    parameter bit FLASH_VARIANT = 1'b0,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rst_pin_n,
    input  logic                       hwstby_pin_n,
    input  logic                       irq_pin,
    input  logic                       sleep_req,
    input  logic                       stby_en,
    input  logic                       edge_rise,
    input  logic [2:0]                 wait_sel,
    output logic                       clk_en,
    output logic                       in_sleep,
    output logic                       in_swstby,
    output logic                       in_hwstby,
    output logic                       wake_pulse,
    output logic                       rst_exc,
    output logic                       cfg_err,
    output logic [stbw_pkg::CNT_W-1:0] wait_count
);
    import stbw_pkg::*;

    logic rst_s, hw_s, irq_s, irq_hit, t_zero, t_load;
    stbw_state_e state, nxt;

    stbw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rst (
        .clk(clk), .rst(rst), .d(rst_pin_n), .q(rst_s));
    stbw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hw (
        .clk(clk), .rst(rst), .d(hwstby_pin_n), .q(hw_s));
    stbw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_irq (
        .clk(clk), .rst(rst), .d(irq_pin), .q(irq_s));

    stbw_edge u_edge (
        .clk(clk), .rst(rst), .sig(irq_s), .rise_sel(edge_rise), .hit(irq_hit));

    assign wait_count = wait_states(wait_sel);
    assign cfg_err    = code_illegal(wait_sel, FLASH_VARIANT);

    always_comb begin
        nxt = state;
        if (!hw_s)
            nxt = ST_HWSTBY;
        else if (state == ST_HWSTBY)
            nxt = ST_RESET;
        else if (!rst_s)
            nxt = ST_RESET;
        else begin
            case (state)
                ST_RESET:  nxt = ST_ACTIVE;
                ST_ACTIVE: if (sleep_req) nxt = stby_en ? ST_SWSTBY : ST_SLEEP;
                ST_SLEEP:  if (irq_hit) nxt = ST_ACTIVE;
                ST_SWSTBY: if (irq_hit) nxt = ST_STAB;
                ST_STAB:   if (t_zero) nxt = ST_ACTIVE;
                default:   nxt = ST_RESET;
            endcase
        end
    end

    assign t_load = (state == ST_SWSTBY) && (nxt == ST_STAB);

    stbw_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(wait_count),
        .run(state == ST_STAB), .zero(t_zero));

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_ACTIVE;
            wake_pulse <= 1'b0;
            rst_exc    <= 1'b0;
        end else begin
            state      <= nxt;
            wake_pulse <= ((state == ST_STAB) || (state == ST_SLEEP)) && (nxt == ST_ACTIVE);
            rst_exc    <= (state == ST_RESET) && (nxt == ST_ACTIVE);
        end
    end

    assign clk_en    = (state == ST_ACTIVE) || (state == ST_RESET);
    assign in_sleep  = (state == ST_SLEEP);
    assign in_swstby = (state == ST_SWSTBY);
    assign in_hwstby = (state == ST_HWSTBY);

    // R1: a qualified request while running lands in software standby
    a_r1_enter_swstby: assert property (@(posedge clk) disable iff (rst)
        (clk_en && !rst_exc && state == ST_ACTIVE && sleep_req && stby_en && hw_s && rst_s)
        |=> (in_swstby && !clk_en));
    // R5: the wake pulse lasts one cycle and marks the clock returning
    a_r5_wake_single: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);
    a_r5_wake_clk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (clk_en && !$past(clk_en)));
    // R9: the synchronized standby pin always forces hardware standby
    a_r9_hw_forced: assert property (@(posedge clk) disable iff (rst)
        !hw_s |=> (in_hwstby && !clk_en));
    // R8: a low reset pin keeps the clocks on
    a_r8_rst_clocks: assert property (@(posedge clk) disable iff (rst)
        (hw_s && !rst_s && !in_hwstby) |=> (clk_en && !in_sleep && !in_swstby));
endmodule

// File: tb/sim_stby_wake_seq.sv
module sim_stby_wake_seq;
    logic clk = 1'b0;
    logic rst, rst_pin_n, hwstby_pin_n, irq_pin, sleep_req, stby_en, edge_rise;
    logic [2:0] wait_sel;
    logic clk_en, in_sleep, in_swstby, in_hwstby, wake_pulse, rst_exc, cfg_err;
    logic [18:0] wait_count;
    logic f_clk_en, f_sleep, f_sw, f_hw, f_wake, f_rexc, f_err;
    logic [18:0] f_cnt;
    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    stby_wake_seq u0 (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .hwstby_pin_n(hwstby_pin_n),
        .irq_pin(irq_pin), .sleep_req(sleep_req), .stby_en(stby_en),
        .edge_rise(edge_rise), .wait_sel(wait_sel), .clk_en(clk_en),
        .in_sleep(in_sleep), .in_swstby(in_swstby), .in_hwstby(in_hwstby),
        .wake_pulse(wake_pulse), .rst_exc(rst_exc), .cfg_err(cfg_err),
        .wait_count(wait_count));

    stby_wake_seq #(.FLASH_VARIANT(1'b1)) u1 (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .hwstby_pin_n(hwstby_pin_n),
        .irq_pin(irq_pin), .sleep_req(sleep_req), .stby_en(stby_en),
        .edge_rise(edge_rise), .wait_sel(wait_sel), .clk_en(f_clk_en),
        .in_sleep(f_sleep), .in_swstby(f_sw), .in_hwstby(f_hw),
        .wake_pulse(f_wake), .rst_exc(f_rexc), .cfg_err(f_err),
        .wait_count(f_cnt));

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic longint exp_states(input int code);
        if (code == 6) return 262144;
        if (code == 7) return 16;
        return longint'(8192) << code;
    endfunction

    task automatic enter_low(input bit sw);
        sleep_req = 1'b1;
        stby_en   = sw;
        edges(1);
        sleep_req = 1'b0;
        if (sw) check(in_swstby == 1'b1 && clk_en == 1'b0, "R1", "swstby entry", in_swstby, 1);
        else    check(in_sleep == 1'b1 && clk_en == 1'b0, "R1", "sleep entry", in_sleep, 1);
    endtask

    task automatic t_reset_state;
        rst = 1'b1; rst_pin_n = 1'b1; hwstby_pin_n = 1'b1; irq_pin = 1'b1;
        sleep_req = 1'b0; stby_en = 1'b0; edge_rise = 1'b0; wait_sel = 3'b000;
        edges(3);
        rst = 1'b0;
        check(clk_en == 1'b1, "R10", "clk_en after reset", clk_en, 1);
        check({in_sleep, in_swstby, in_hwstby, wake_pulse, rst_exc} == 5'b0,
              "R10", "flags after reset", {in_sleep, in_swstby, in_hwstby, wake_pulse, rst_exc}, 0);
        edges(4);
    endtask

    task automatic t_codes;
        for (int c = 0; c < 8; c++) begin
            wait_sel = 3'(c);
            #1;
            check(wait_count == 19'(exp_states(c)), "R2", "wait_count", wait_count, exp_states(c));
            if (c < 6) check(wait_count > 19'd4096, "R2", "above settle budget", wait_count, 4097);
            check(cfg_err == (c == 6), "R3", "cfg_err default", cfg_err, (c == 6));
            check(f_err == (c >= 6), "R3", "cfg_err flash", f_err, (c >= 6));
        end
        @(negedge clk);
    endtask

    task automatic t_active_edges;
        edge_rise = 1'b0;
        for (int i = 0; i < 4; i++) begin
            irq_pin = ~irq_pin;
            edges(4);
            check(clk_en == 1'b1 && wake_pulse == 1'b0 && !in_sleep && !in_swstby,
                  "R6", "edge while running", clk_en, 1);
        end
    endtask

    task automatic t_swstby(input int code, input bit rise, input bit glitch);
        int k;
        edge_rise = rise;
        irq_pin   = ~rise;
        wait_sel  = 3'(code);
        edges(4);
        enter_low(1'b1);
        irq_pin = rise;
        k = 0;
        do begin
            edges(1);
            k++;
            if (glitch && k == 6) irq_pin = ~rise;
            if (glitch && k == 9) irq_pin = rise;
        end while (!clk_en && k < 300000);
        check(k == exp_states(code) + 4, "R5", "edges to clk_en", k, exp_states(code) + 4);
        if (glitch) check(k == exp_states(code) + 4, "R6", "countdown not restarted", k, exp_states(code) + 4);
        check(wake_pulse == 1'b1, "R5", "wake pulse high", wake_pulse, 1);
        edges(1);
        check(wake_pulse == 1'b0 && clk_en == 1'b1, "R5", "wake pulse single", wake_pulse, 0);
    endtask

    task automatic t_wrong_edge;
        int k;
        edge_rise = 1'b0;
        wait_sel  = 3'b111;
        irq_pin   = 1'b0;
        edges(4);
        enter_low(1'b1);
        irq_pin = 1'b1;
        edges(10);
        check(in_swstby == 1'b1 && clk_en == 1'b0, "R4", "opposite edge ignored", in_swstby, 1);
        irq_pin = 1'b0;
        k = 0;
        do begin edges(1); k++; end while (!clk_en && k < 100);
        check(k == 20, "R4", "falling edge wakes", k, 20);
        edges(2);
    endtask

    task automatic t_sleep;
        edge_rise = 1'b1;
        irq_pin   = 1'b0;
        edges(4);
        enter_low(1'b0);
        irq_pin = 1'b1;
        edges(2);
        check(clk_en == 1'b0 && in_sleep == 1'b1, "R7", "still asleep at edge 2", clk_en, 0);
        edges(1);
        check(clk_en == 1'b1 && wake_pulse == 1'b1, "R7", "wake at edge 3", clk_en, 1);
        edges(1);
        check(wake_pulse == 1'b0, "R7", "pulse ends", wake_pulse, 0);
    endtask

    task automatic t_reset_pin;
        edge_rise = 1'b0;
        irq_pin   = 1'b1;
        wait_sel  = 3'b111;
        edges(4);
        enter_low(1'b1);
        rst_pin_n = 1'b0;
        edges(3);
        check(clk_en == 1'b1 && in_swstby == 1'b0, "R8", "reset pin clocks on", clk_en, 1);
        edges(5);
        check(clk_en == 1'b1 && rst_exc == 1'b0, "R8", "held in reset", rst_exc, 0);
        rst_pin_n = 1'b1;
        edges(2);
        check(rst_exc == 1'b0, "R8", "no early exc", rst_exc, 0);
        edges(1);
        check(rst_exc == 1'b1, "R8", "exc pulse", rst_exc, 1);
        edges(1);
        check(rst_exc == 1'b0, "R8", "exc single", rst_exc, 0);
    endtask

    task automatic t_hw;
        hwstby_pin_n = 1'b0;
        edges(2);
        check(in_hwstby == 1'b0, "R9", "not yet hw standby", in_hwstby, 0);
        edges(1);
        check(in_hwstby == 1'b1 && clk_en == 1'b0, "R9", "hw standby from running", in_hwstby, 1);
        hwstby_pin_n = 1'b1;
        edges(3);
        check(in_hwstby == 1'b0 && clk_en == 1'b1 && rst_exc == 1'b0, "R9", "reset state after release", clk_en, 1);
        edges(1);
        check(rst_exc == 1'b1, "R9", "exc after release", rst_exc, 1);
        edge_rise = 1'b0;
        irq_pin   = 1'b1;
        wait_sel  = 3'b000;
        edges(4);
        enter_low(1'b1);
        irq_pin = 1'b0;
        edges(100);
        hwstby_pin_n = 1'b0;
        edges(3);
        check(in_hwstby == 1'b1 && clk_en == 1'b0, "R9", "hw standby in countdown", in_hwstby, 1);
        edges(8300);
        check(wake_pulse == 1'b0 && clk_en == 1'b0, "R9", "no wake in hw standby", clk_en, 0);
        hwstby_pin_n = 1'b1;
        edges(6);
    endtask

    initial begin
        t_reset_state();
        t_codes();
        t_active_edges();
        t_swstby(7, 1'b0, 1'b0);
        t_swstby(7, 1'b1, 1'b0);
        t_swstby(7, 1'b1, 1'b1);
        t_swstby(0, 1'b0, 1'b0);
        t_swstby(1, 1'b1, 1'b0);
        t_wrong_edge();
        t_sleep();
        t_reset_pin();
        t_hw();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog all-R actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule